// File: doc/BRIEF.md
# GPIO Port with Pull-up Control

This block is one general-purpose I/O port of a small peripheral bus. Each of its pins is governed by two writable bits, a direction bit and a level bit, and offers a third, read-only bit carrying the synchronized pad level. Software reaches the three groups through three distinct bus addresses, using a write strobe and a read strobe. For every pin the block drives an output enable, an output level and a pull-up enable toward the pad cell.

The level bit has two meanings. When its pin is an output, it sets the driven level. When its pin is an input, it enables the pull-up. A global pull-up kill input overrides every pull-up, whatever the registers hold. The port floats all pads as soon as reset is asserted, without waiting for a clock edge. While the sleep input is high, the pad inputs are blocked from the synchronizer so that a floating pad cannot toggle internal logic.

Top module: `gpio_port`

## Requirements
- R1: Asserting the active-low reset clears the direction and level registers at once, with no clock edge needed. All output enables and pull-up enables then read 0, and both registers read back as 0.
- R2: A direction bit of 1 makes its pin an output: the output enable is 1 and the output level equals the level bit. A direction bit of 0 gives an output enable of 0 and an output level of 0.
- R3: For an input pin (direction 0), a level bit of 1 turns the pull-up enable on and a level bit of 0 turns it off.
- R4: The pull-up enable of a pin is always 0 while its direction bit is 1.
- R5: While the global pull-up kill input is 1, every pull-up enable is 0. The register contents are left unchanged, so the pull-ups return once the kill input drops.
- R6: A read at the level address (1) returns the stored level register, never the pad level. A read at the direction address (0) returns the direction register.
- R7: A read at the pin address (2) returns the pad inputs after two flip-flops on the port clock. A pad change made before a rising edge is not visible after that edge and is visible after the next one.
- R8: While sleep is 1, the synchronizer input is forced to 0, so the pin address reads 0 two edges after sleep rises. Sleep leaves the output enables, output levels and pull-up enables unchanged.
- R9: A write to the pin address (2) changes no register and no pad control. A read of an unmapped address (3) returns 0. The read data is 0 whenever the read strobe is low.
- R10: The direction and level bits are written separately, and every one of the four combinations gives its defined pad control. The path runs tri-state 00 → pull-up 01 → output high 11 → drive low 10 → tri-state 00, with direction written first. A write to one register never alters the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock; also clocks the pin synchronizer |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | Register address: 0 direction, 1 level, 2 pin value |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | W | Write data |
| rdata | output | W | Read data, combinational, 0 when rd_en is low |
| pu_kill | input | 1 | Global pull-up disable |
| sleep | input | 1 | Sleep request; blocks pad inputs from the synchronizer |
| pad_in | input | W | Pad levels seen from the pins |
| pad_oe | output | W | Per-pin output enable |
| pad_out | output | W | Per-pin driven level |
| pad_pu | output | W | Per-pin pull-up enable |

## Verification
The bench builds the port with its default values: eight pins and a two-bit address, with direction at 0, level at 1 and pin value at 2. This leaves address 3 free, so the unmapped-read rule can be checked at the ports. With eight pins, one write can put pins in input and output modes at the same time, for example direction 0x0F with level 0xA5, so the dual role of the level bit is checked on both halves in a single vector. The synchronizer latency is checked one edge at a time. Reset is also asserted between clock edges to show that the pads float without a clock.

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int W        = 8,
  parameter int AW       = 2,
  parameter int ADDR_DIR = 0,
  parameter int ADDR_LVL = 1,
  parameter int ADDR_PIN = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  input  logic          pu_kill,
  input  logic          sleep,
  input  logic [W-1:0]  pad_in,
  output logic [W-1:0]  pad_oe,
  output logic [W-1:0]  pad_out,
  output logic [W-1:0]  pad_pu
);

  logic [W-1:0] dir_q, lvl_q, meta_q, pin_q;
  logic         hit_dir, hit_lvl, hit_pin;

  assign hit_dir = (addr == AW'(ADDR_DIR));
  assign hit_lvl = (addr == AW'(ADDR_LVL));
  assign hit_pin = (addr == AW'(ADDR_PIN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      lvl_q <= '0;
    end else if (wr_en) begin
      if (hit_dir) dir_q <= wdata;
      if (hit_lvl) lvl_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      pin_q  <= '0;
    end else begin
      meta_q <= sleep ? '0 : pad_in;
      pin_q  <= meta_q;
    end
  end

  assign pad_oe  = dir_q;
  assign pad_out = dir_q & lvl_q;
  assign pad_pu  = ~dir_q & lvl_q & {W{~pu_kill}};

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (hit_dir)      rdata = dir_q;
      else if (hit_lvl) rdata = lvl_q;
      else if (hit_pin) rdata = pin_q;
    end
  end

  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= '0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  p_float_on_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pad_oe == '0 && pad_pu == '0));

  p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_dir) |=> (pad_oe == $past(wdata)));

  p_no_pu_on_output_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_dir) |=> ((pad_pu & $past(wdata)) == '0));

  p_lvl_readback_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en && hit_lvl) && rd_en && hit_lvl) |-> (rdata == $past(wdata)));

  p_sync_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3 && !$past(sleep) && !$past(sleep, 2)) |-> (pin_q == $past(pad_in, 2)));

  p_sleep_holds_pads_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && !wr_en) |=> ($stable(pad_oe) && $stable(pad_out)));

  p_pin_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_pin) |=> ($stable(pad_oe) && $stable(pad_out)));

endmodule

// File: tb/gpio_port_bench.sv
module gpio_port_bench;
  localparam int W = 8;
  localparam int AW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          wr_en, rd_en, pu_kill, sleep;
  logic [W-1:0]  wdata, pad_in;
  logic [W-1:0]  rdata, pad_oe, pad_out, pad_pu;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done  = 0;

  always #5 clk = ~clk;

  gpio_port #(.W(W), .AW(AW)) u_gpio_port (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .pu_kill(pu_kill), .sleep(sleep),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [W-1:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic t_reset;
    logic [W-1:0] v;
    wr(2'd0, 8'hF0); wr(2'd1, 8'hFF);
    @(negedge clk); #2;
    rst_n = 1'b0;
    #1;
    chk("R1 oe cleared without edge", pad_oe, 8'h00);
    chk("R1 pu cleared without edge", pad_pu, 8'h00);
    rd(2'd0, v); chk("R1 dir reads 0", v, 8'h00);
    rd(2'd1, v); chk("R1 lvl reads 0", v, 8'h00);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_mixed;
    wr(2'd0, 8'h0F); wr(2'd1, 8'hA5); #1;
    chk("R2 oe follows dir", pad_oe, 8'h0F);
    chk("R2 out on output pins", pad_out, 8'h05);
    chk("R3 pull-up on input pins", pad_pu, 8'hA0);
  endtask

  task automatic t_output_no_pu;
    wr(2'd1, 8'hFF); wr(2'd0, 8'hFF); #1;
    chk("R4 no pull-up when output", pad_pu, 8'h00);
    chk("R2 drive high", pad_out, 8'hFF);
  endtask

  task automatic t_kill;
    logic [W-1:0] v;
    wr(2'd0, 8'h00); wr(2'd1, 8'h3C); #1;
    chk("R3 pull-up pattern", pad_pu, 8'h3C);
    @(negedge clk); pu_kill = 1'b1; #1;
    chk("R5 kill forces pull-ups off", pad_pu, 8'h00);
    rd(2'd1, v); chk("R5 lvl kept under kill", v, 8'h3C);
    @(negedge clk); pu_kill = 1'b0; #1;
    chk("R5 pull-ups return", pad_pu, 8'h3C);
  endtask

  task automatic t_readback;
    logic [W-1:0] v;
    @(negedge clk); pad_in = 8'h00;
    wr(2'd0, 8'hFF); wr(2'd1, 8'hC3);
    repeat (2) @(negedge clk);
    rd(2'd1, v); chk("R6 lvl returns latch not pad", v, 8'hC3);
    rd(2'd0, v); chk("R6 dir readback", v, 8'hFF);
    rd(2'd2, v); chk("R6 pin returns pad", v, 8'h00);
  endtask

  task automatic t_sync;
    logic [W-1:0] v;
    @(negedge clk); pad_in = 8'h5A;
    @(negedge clk);
    rd(2'd2, v); chk("R7 not visible after one edge", v, 8'h00);
    @(negedge clk);
    rd(2'd2, v); chk("R7 visible after two edges", v, 8'h5A);
  endtask

  task automatic t_sleep;
    logic [W-1:0] v, oe0, out0, pu0;
    @(negedge clk); pad_in = 8'hFF;
    repeat (2) @(negedge clk);
    rd(2'd2, v); chk("R7 pad FF synced", v, 8'hFF);
    oe0 = pad_oe; out0 = pad_out; pu0 = pad_pu;
    sleep = 1'b1;
    repeat (2) @(negedge clk);
    rd(2'd2, v); chk("R8 pin gated to 0 in sleep", v, 8'h00);
    chk("R8 oe unchanged", pad_oe, oe0);
    chk("R8 out unchanged", pad_out, out0);
    chk("R8 pu unchanged", pad_pu, pu0);
    sleep = 1'b0;
    repeat (2) @(negedge clk);
    rd(2'd2, v); chk("R8 pin resumes after sleep", v, 8'hFF);
  endtask

  task automatic t_pin_ro;
    logic [W-1:0] v, oe0, out0;
    oe0 = pad_oe; out0 = pad_out;
    wr(2'd2, 8'h5A); #1;
    rd(2'd0, v); chk("R9 dir unchanged by pin write", v, oe0);
    rd(2'd1, v); chk("R9 lvl unchanged by pin write", v, 8'hC3);
    chk("R9 out unchanged by pin write", pad_out, out0);
    rd(2'd3, v); chk("R9 unmapped reads 0", v, 8'h00);
    addr = 2'd1; #1;
    chk("R9 no read strobe gives 0", rdata, 8'h00);
  endtask

  task automatic t_transitions;
    logic [W-1:0] v;
    wr(2'd0, 8'h00); wr(2'd1, 8'h00); #1;
    chk("R10 00 tri oe", pad_oe, 8'h00);
    chk("R10 00 tri pu", pad_pu, 8'h00);
    wr(2'd1, 8'hFF); #1;
    chk("R10 01 pull-up", pad_pu, 8'hFF);
    chk("R10 01 no drive", pad_oe, 8'h00);
    wr(2'd0, 8'hFF); #1;
    chk("R10 11 drive high", pad_out, 8'hFF);
    chk("R10 11 no pull-up", pad_pu, 8'h00);
    rd(2'd1, v); chk("R10 dir write kept lvl", v, 8'hFF);
    wr(2'd1, 8'h00); #1;
    chk("R10 10 drive low oe", pad_oe, 8'hFF);
    chk("R10 10 drive low out", pad_out, 8'h00);
    rd(2'd0, v); chk("R10 lvl write kept dir", v, 8'hFF);
    wr(2'd0, 8'h00); #1;
    chk("R10 back to tri oe", pad_oe, 8'h00);
    chk("R10 back to tri pu", pad_pu, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; addr = '0; wr_en = 1'b0; rd_en = 1'b0; wdata = '0;
    pu_kill = 1'b0; sleep = 1'b0; pad_in = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 oe at reset", pad_oe, 8'h00);
    chk("R1 pu at reset", pad_pu, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_mixed();
    t_output_no_pu();
    t_kill();
    t_readback();
    t_sync();
    t_sleep();
    t_pin_ro();
    t_transitions();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule